// File: doc/BRIEF.md
# Automatic Sliding Door Controller

This block sequences the drive motor of a sliding door. Three sensor signals come in from outside the clock domain: a presence detector, a limit switch that closes when the door is fully open, and a limit switch that closes when the door is fully shut. Each signal passes through a two-flop synchroniser. Its rising edge sets an event latch that stays set until the controller consumes the event with a one-cycle clear pulse.

The sequencer is a Moore state machine with six states. `ST_IDLE` waits for a presence event. The transition idle-to-opening consumes that event and drives the motor forward. `ST_OPENING` waits for the open-limit event. The transition opening-to-dwell consumes that event and stops the motor. `ST_DWELL` keeps the door open for `CLK_HZ*DWELL_S` clocks. The transition dwell-to-preclose is taken when that count ends. `ST_PRECLOSE` is one clock with the motor still off and the direction set to reverse. The transition preclose-to-closing then starts the motor in reverse. `ST_CLOSING` waits for the closed-limit event. The transition closing-to-park consumes that event and stops the motor. `ST_PARK` is one clock with the motor off while the direction is still reverse. The transition park-to-idle returns the direction to forward.

The controller does not reopen the door while it is closing. An event that arrives in a state that does not test for it stays latched until a state that does test for it is reached.

Top module: `door_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `motor_en_o`, `motor_dir_o` and `ev_clr_o` are all 0.
- R2: A rising edge on `presence_i` seen while idle makes `motor_en_o` 1 with `motor_dir_o` 0 (forward). This happens exactly 4 rising clock edges after the input rises: 2 synchroniser stages, the latch, and the state register.
- R3: The presence event is consumed by a one-cycle pulse on `ev_clr_o` bit 0. The pulse falls in the last idle cycle before the motor starts.
- R4: While opening, an open-limit event stops the motor. It is consumed by a one-cycle pulse on `ev_clr_o` bit 1 in the last cycle that the motor runs.
- R5: After the open stop, the motor stays off with direction forward for exactly `CLK_HZ*DWELL_S` cycles. Then one cycle follows with the motor off and `motor_dir_o` 1 (reverse). After that, the motor runs in reverse.
- R6: While closing, a closed-limit event stops the motor. It is consumed by a pulse on `ev_clr_o` bit 2. One cycle with the motor off and direction reverse follows, and then the controller is idle with direction forward.
- R7: `motor_dir_o` changes only in a cycle where `motor_en_o` is 0 and was also 0 in the previous cycle.
- R8: A presence event that arrives while the door is opening, dwelling or closing does not interrupt closing. It stays latched and reopens the door as soon as the controller is idle again.
- R9: A level held high on an input produces only one event. Presence kept high through a whole cycle leaves the door closed and idle afterwards.
- R10: Reset asserted in mid-operation stops the motor and clears every event latch. A presence event latched before the reset does not start the motor afterwards.
- R11: At most one bit of `ev_clr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| presence_i | input | 1 | Presence detector, asynchronous |
| open_lim_i | input | 1 | Fully-open limit switch, asynchronous |
| close_lim_i | input | 1 | Fully-closed limit switch, asynchronous |
| motor_en_o | output | 1 | Motor run enable |
| motor_dir_o | output | 1 | Motor direction: 0 opens, 1 closes |
| ev_clr_o | output | 3 | Event clear pulses: bit 0 presence, bit 1 open limit, bit 2 closed limit |

## Verification
The assertions assume three things about the inputs. The limit switches report only a position the motor has actually reached. Each sensor level stays stable for at least two clocks, so the synchroniser sees every edge. Reset lasts at least one full clock. The bench meets these conditions in three ways. It changes inputs only on falling clock edges. It holds each sensor high for several cycles. It raises a limit input only after the motor has run in the matching direction, so a stale limit event is never left waiting when a new cycle starts.

// File: rtl/door_pkg.sv
package door_pkg;

    localparam int NUM_EV   = 3;
    localparam int EV_PRES  = 0;
    localparam int EV_OPEN  = 1;
    localparam int EV_CLOSE = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPENING,
        ST_DWELL,
        ST_PRECLOSE,
        ST_CLOSING,
        ST_PARK
    } door_state_t;

endpackage

// File: rtl/door_event_latch.sv
module door_event_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic clr_i,
    output logic full_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // A fresh edge wins over a clear in the same cycle, so no event is lost.
    always_ff @(posedge clk) begin
        if (rst)        full_o <= 1'b0;
        else if (rise)  full_o <= 1'b1;
        else if (clr_i) full_o <= 1'b0;
    end

    // R8: an unconsumed event stays latched
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (full_o && !clr_i) |=> full_o);

    // R3: a clear with no new edge empties the latch
    p_clear_consumes_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !rise) |=> !full_o);

endmodule

// File: rtl/door_dwell_timer.sv
module door_dwell_timer #(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned DWELL_S = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);

    localparam longint unsigned DWELL_CYC = longint'(CLK_HZ) * longint'(DWELL_S);
    localparam int              CW        = $clog2(DWELL_CYC + 1);
    localparam logic [CW-1:0]   LAST      = CW'(DWELL_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Counter restarts from zero whenever the dwell state is not active.
    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (!done_o)  cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);

    // R5: the count starts from zero on entry to the dwell
    p_dwell_fresh_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |-> (cnt_q == '0));

endmodule

// File: rtl/door_fsm.sv
module door_fsm
    import door_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_full_i,
    input  logic              dwell_done_i,
    output logic              motor_en_o,
    output logic              motor_dir_o,
    output logic [NUM_EV-1:0] ev_clr_o,
    output logic              dwell_run_o
);

    door_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ev_full_i[EV_PRES])  state_d = ST_OPENING;
            ST_OPENING:  if (ev_full_i[EV_OPEN])  state_d = ST_DWELL;
            ST_DWELL:    if (dwell_done_i)        state_d = ST_PRECLOSE;
            ST_PRECLOSE:                          state_d = ST_CLOSING;
            ST_CLOSING:  if (ev_full_i[EV_CLOSE]) state_d = ST_PARK;
            ST_PARK:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        motor_en_o  = 1'b0;
        motor_dir_o = 1'b0;
        ev_clr_o    = '0;
        dwell_run_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     ev_clr_o[EV_PRES] = ev_full_i[EV_PRES];
            ST_OPENING: begin
                motor_en_o         = 1'b1;
                ev_clr_o[EV_OPEN]  = ev_full_i[EV_OPEN];
            end
            ST_DWELL:    dwell_run_o = 1'b1;
            ST_PRECLOSE: motor_dir_o = 1'b1;
            ST_CLOSING: begin
                motor_en_o         = 1'b1;
                motor_dir_o        = 1'b1;
                ev_clr_o[EV_CLOSE] = ev_full_i[EV_CLOSE];
            end
            ST_PARK:     motor_dir_o = 1'b1;
            default: ;
        endcase
    end

    // R7: direction moves only with the motor stopped for two cycles
    p_dir_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(motor_dir_o) |-> (!motor_en_o && !$past(motor_en_o)));

    // R11: never more than one clear pulse at a time
    p_clr_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_clr_o));

    // R2: a latched presence in idle starts the motor forward next cycle
    p_start_open_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && ev_full_i[EV_PRES]) |=> (motor_en_o && !motor_dir_o));

    // R4: open-limit event while opening stops the motor next cycle
    p_stop_open_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPENING && ev_full_i[EV_OPEN]) |=> !motor_en_o);

    // R5: end of dwell leads to the reverse-set idle cycle
    p_dwell_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DWELL && dwell_done_i) |=> (!motor_en_o && motor_dir_o));

    // R6: closed-limit event while closing stops the motor next cycle
    p_stop_close_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLOSING && ev_full_i[EV_CLOSE]) |=> !motor_en_o);

    // R1: the cycle after reset is idle with everything off
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!motor_en_o && !motor_dir_o && ev_clr_o == '0));

endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
    import door_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned DWELL_S     = 5,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              presence_i,
    input  logic              open_lim_i,
    input  logic              close_lim_i,
    output logic              motor_en_o,
    output logic              motor_dir_o,
    output logic [NUM_EV-1:0] ev_clr_o
);

    logic [NUM_EV-1:0] raw_vec;
    logic [NUM_EV-1:0] full_vec;
    logic              dwell_run;
    logic              dwell_done;

    always_comb begin
        raw_vec           = '0;
        raw_vec[EV_PRES]  = presence_i;
        raw_vec[EV_OPEN]  = open_lim_i;
        raw_vec[EV_CLOSE] = close_lim_i;
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        door_event_latch #(
            .SYNC_STAGES(SYNC_STAGES)
        ) latch_i (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_vec[g]),
            .clr_i  (ev_clr_o[g]),
            .full_o (full_vec[g])
        );
    end

    door_dwell_timer #(
        .CLK_HZ  (CLK_HZ),
        .DWELL_S (DWELL_S)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (dwell_run),
        .done_o (dwell_done)
    );

    door_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .ev_full_i    (full_vec),
        .dwell_done_i (dwell_done),
        .motor_en_o   (motor_en_o),
        .motor_dir_o  (motor_dir_o),
        .ev_clr_o     (ev_clr_o),
        .dwell_run_o  (dwell_run)
    );

endmodule

// File: tb/door_ctrl_tb_top.sv
`timescale 1ns/1ps
module door_ctrl_tb_top;

    localparam int unsigned CLK_HZ  = 20;
    localparam int unsigned DWELL_S = 5;
    localparam int          DWELL   = CLK_HZ * DWELL_S;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       presence_i = 1'b0;
    logic       open_lim_i = 1'b0;
    logic       close_lim_i = 1'b0;
    logic       motor_en_o;
    logic       motor_dir_o;
    logic [2:0] ev_clr_o;

    int checks = 0;
    int fails  = 0;

    door_ctrl #(.CLK_HZ(CLK_HZ), .DWELL_S(DWELL_S)) dut_i (
        .clk(clk), .rst(rst), .presence_i(presence_i), .open_lim_i(open_lim_i),
        .close_lim_i(close_lim_i), .motor_en_o(motor_en_o),
        .motor_dir_o(motor_dir_o), .ev_clr_o(ev_clr_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_clr(input int max, output logic [2:0] v);
        v = '0;
        for (int i = 0; i < max; i++) begin
            step();
            if (ev_clr_o != 3'b000) begin
                v = ev_clr_o;
                break;
            end
        end
    endtask

    // Starts from idle, presence already latched or about to be.
    task automatic wait_en(input int max);
        for (int i = 0; i < max; i++) begin
            if (motor_en_o) break;
            step();
        end
    endtask

    task automatic finish_open_and_close();
        logic [2:0] v;
        open_lim_i = 1'b1;
        wait_clr(10, v);
        open_lim_i = 1'b0;
        for (int i = 0; i < DWELL + 5; i++) begin
            if (motor_en_o && motor_dir_o) break;
            step();
        end
        close_lim_i = 1'b1;
        wait_clr(10, v);
        close_lim_i = 1'b0;
        step();
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        chk(!motor_en_o && !motor_dir_o && ev_clr_o == 0, "R1 in reset", {motor_en_o, motor_dir_o}, 0);
        step();
        rst = 1'b0;
        step();
        chk(!motor_en_o && !motor_dir_o && ev_clr_o == 0, "R1 after reset", {motor_en_o, motor_dir_o}, 0);
    endtask

    task automatic t_full_cycle();
        logic [2:0] v;
        int cnt;
        presence_i = 1'b1;
        step(); step(); step();
        chk(ev_clr_o == 3'b001 && !motor_en_o, "R3 presence clear", ev_clr_o, 1);
        step();
        chk(motor_en_o && !motor_dir_o, "R2 open after 4 edges", {motor_en_o, motor_dir_o}, 2);
        chk(ev_clr_o == 3'b000, "R3 clear one cycle", ev_clr_o, 0);
        presence_i = 1'b0;
        for (int i = 0; i < 6; i++) step();
        open_lim_i = 1'b1;
        wait_clr(10, v);
        chk(v == 3'b010 && motor_en_o, "R4 open-limit clear", v, 2);
        step();
        open_lim_i = 1'b0;
        chk(!motor_en_o, "R4 motor stops at open", motor_en_o, 0);
        cnt = 0;
        while (!motor_en_o && !motor_dir_o && cnt < DWELL + 10) begin
            cnt++;
            step();
        end
        chk(cnt == DWELL, "R5 dwell length", cnt, DWELL);
        chk(!motor_en_o && motor_dir_o, "R5 reverse set while off", {motor_en_o, motor_dir_o}, 1);
        step();
        chk(motor_en_o && motor_dir_o, "R5 closing runs reverse", {motor_en_o, motor_dir_o}, 3);
        for (int i = 0; i < 6; i++) step();
        close_lim_i = 1'b1;
        wait_clr(10, v);
        chk(v == 3'b100 && motor_en_o, "R6 close-limit clear", v, 4);
        step();
        close_lim_i = 1'b0;
        chk(!motor_en_o && motor_dir_o, "R6 park cycle", {motor_en_o, motor_dir_o}, 1);
        step();
        chk(!motor_en_o && !motor_dir_o, "R6 idle forward", {motor_en_o, motor_dir_o}, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (motor_en_o) cnt++;
        end
        chk(cnt == 0, "R6 stays idle", cnt, 0);
    endtask

    task automatic t_level_hold();
        int cnt;
        presence_i = 1'b1;
        wait_en(10);
        chk(motor_en_o && !motor_dir_o, "R9 held presence opens", {motor_en_o, motor_dir_o}, 2);
        finish_open_and_close();
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (motor_en_o) cnt++;
        end
        chk(cnt == 0, "R9 no retrigger on level", cnt, 0);
        presence_i = 1'b0;
        step();
    endtask

    task automatic t_presence_in_close();
        logic [2:0] v;
        int bad;
        presence_i = 1'b1;
        wait_en(10);
        presence_i = 1'b0;
        open_lim_i = 1'b1;
        wait_clr(10, v);
        open_lim_i = 1'b0;
        for (int i = 0; i < DWELL + 5; i++) begin
            if (motor_en_o && motor_dir_o) break;
            step();
        end
        presence_i = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            step();
            if (!(motor_en_o && motor_dir_o)) bad++;
        end
        presence_i = 1'b0;
        chk(bad == 0, "R8 closing not interrupted", bad, 0);
        close_lim_i = 1'b1;
        wait_clr(10, v);
        chk(v == 3'b100, "R6 close-limit clear", v, 4);
        close_lim_i = 1'b0;
        wait_clr(5, v);
        chk(v == 3'b001, "R8 retained presence consumed", v, 1);
        step();
        chk(motor_en_o && !motor_dir_o, "R8 door reopens", {motor_en_o, motor_dir_o}, 2);
        finish_open_and_close();
    endtask

    task automatic t_reset_mid();
        int cnt;
        presence_i = 1'b1;
        wait_en(10);
        presence_i = 1'b0;
        for (int i = 0; i < 3; i++) step();
        presence_i = 1'b1;
        for (int i = 0; i < 5; i++) step();
        presence_i = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(!motor_en_o && !motor_dir_o && ev_clr_o == 0, "R10 reset stops motor", motor_en_o, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (motor_en_o || ev_clr_o != 0) cnt++;
        end
        chk(cnt == 0, "R10 latched presence dropped", cnt, 0);
    endtask

    // Independent monitor for R7 and R11 during all scenarios.
    logic prev_en, prev_dir;
    always @(negedge clk) begin
        if (!rst) begin
            if (motor_dir_o !== prev_dir && (motor_en_o || prev_en))
                chk(1'b0, "R7 direction change with motor on", motor_dir_o, prev_dir);
            if ($countones(ev_clr_o) > 1)
                chk(1'b0, "R11 clear pulses one-hot", ev_clr_o, 0);
        end
        prev_en  <= motor_en_o;
        prev_dir <= motor_dir_o;
    end

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full_cycle();
        t_level_hold();
        t_presence_in_close();
        t_reset_mid();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule